// File: doc/BRIEF.md
# Compare-Match Periodic Timer Channel

This block is one channel of a multi-channel timer. It has a 16-bit up-counter driven by a prescaled tick, one 16-bit compare register, a set of byte-wide control registers and a single status flag. When the counter reaches the compare value, the channel sets its flag. It can also raise an interrupt and drive a compare output pin. If clear-on-compare is selected, the counter returns to zero on the following tick, so the channel produces a fixed period. Only normal counting is implemented. Software reaches the channel through a byte bus with combinational read data.

A start/stop register sits outside the channel and is shared by several channels. Its bits arrive on `run_vec`, and the channel looks only at bit `CH_IDX`. A typical periodic setup selects clear on compare, a divide-by-64 prescale and the rising edge, then loads the compare value and enables the interrupt. Each interrupt is acknowledged by reading the status register and then writing zero to the flag bit.

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0, the counter is 0, and `irq` and `cmp_pin` are 0. The byte offsets are: control 0, mode 1, pin control 2, interrupt enable 3, status 4, counter high/low 6/7, compare high/low 8/9.
- R2: The counter holds its value while `run_vec[CH_IDX]` is 0, whatever the other `run_vec` bits are.
- R3: Control bits 1:0 pick the prescale divide: 0→1, 1→4, 2→16, 3→64 system clocks per tick. Bit 2 is stored and ignored. With rising-edge counting and a divide of N, the first tick comes N cycles after the run bit rises.
- R4: Control bits 4:3 pick the tick edge. 0 is rising: tick when the phase counter (reset to 0 while stopped) has its low log2(N) bits all ones. 1 is falling: tick when those bits equal N/2−1. 2 or 3 is both edges. With divide-by-1 there is exactly one tick per cycle in every edge mode.
- R5: When control bits 7:5 equal 1, a tick with the counter equal to the compare value loads 0. Any other value lets the counter run through 0xFFFF to 0.
- R6: Status bit 0 sets on the tick where the counter takes the compare value.
- R7: Status bit 0 clears only when zero is written to it after it has been read as 1. Writing 1, or writing 0 with no prior read, leaves it set.
- R8: `irq` is high exactly when status bit 0 and enable bit 0 (offset 3) are both 1.
- R9: The low nibble of pin control sets the compare action. Writing 1, 2 or 3 drives the pin to 0 and 5, 6 or 7 drives it to 1. On a match the pin is cleared (codes 1, 5), set (2, 6) or toggled (3, 7). Code 0 and any other code retain the pin.
- R10: A bus write to a counter byte replaces that byte and suppresses the count tick in that cycle.
- R11: The mode register (offset 1) reads back what was written and has no effect on counting.
- R12: With clear on compare and divide-by-64, successive compare flags are (compare+1)·64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| run_vec | input | NUM_CH | Shared start/stop bits, one per channel |
| cmp_pin | output | 1 | Compare-match output pin |
| irq | output | 1 | Compare-match interrupt request |

## Verification
A wrong prescaler phase or edge decode makes the counter, read after a known number of run cycles, differ from the expected tick count. That shows up the first time the counter is read after a run window. A bad clear or match condition shows within one tick: the counter fails to return to zero, `irq` rises in the wrong cycle, or the period between two flags is wrong. A broken flag-clear handshake or pin action is visible on `irq` or `cmp_pin` one cycle after the offending write or match.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   localparam int A_CTRL = 0;
   localparam int A_MODE = 1;
   localparam int A_PINC = 2;
   localparam int A_IEN  = 3;
   localparam int A_STAT = 4;
   localparam int A_CNTH = 6;
   localparam int A_CNTL = 7;
   localparam int A_CMPH = 8;
   localparam int A_CMPL = 9;

   localparam logic [2:0] CLR_ON_CMP = 3'd1;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_ALT  = 2'd3
   } edge_e;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'd0,
      ACT_CLR  = 2'd1,
      ACT_SET  = 2'd2,
      ACT_TGL  = 2'd3
   } pin_act_e;

   function automatic logic code_valid(input logic [3:0] code);
      return !code[3] && (code[1:0] != 2'd0);
   endfunction

   function automatic pin_act_e pin_act(input logic [3:0] code);
      if (!code_valid(code)) return ACT_KEEP;
      return pin_act_e'(code[1:0]);
   endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
   parameter int NUM_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_sel,
   input  logic [1:0] edge_sel,
   output logic       tick
);
   import cmt_pkg::*;

   localparam int PSC_W = 2 * (NUM_DIV - 1);

   initial begin
      assert (NUM_DIV >= 2 && NUM_DIV <= 4)
         else $error("cmt_prescale: NUM_DIV out of range");
   end

   logic [PSC_W-1:0]   psc_q;
   logic [NUM_DIV-1:0] rise_v;
   logic [NUM_DIV-1:0] fall_v;
   logic [1:0]         sel_idx;
   logic               rise_hit;
   logic               fall_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      psc_q <= '0;
      else if (!run)   psc_q <= '0;
      else             psc_q <= psc_q + PSC_W'(1);
   end

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      localparam logic [PSC_W-1:0] MASK = PSC_W'((64'd1 << (2 * g)) - 64'd1);
      localparam logic [PSC_W-1:0] HALF = MASK >> 1;
      assign rise_v[g] = ((psc_q & MASK) == MASK);
      assign fall_v[g] = ((psc_q & MASK) == HALF);
   end

   assign sel_idx  = (int'(div_sel) >= NUM_DIV) ? 2'(NUM_DIV - 1) : div_sel;
   assign rise_hit = rise_v[sel_idx];
   assign fall_hit = fall_v[sel_idx];

   always_comb begin
      unique case (edge_e'(edge_sel))
         EDGE_RISE: tick = run && rise_hit;
         EDGE_FALL: tick = run && fall_hit;
         default:   tick = run && (rise_hit || fall_hit);
      endcase
   end

   // R3: with a divider above 1 and rising edge, ticks never come back to back
   p_rise_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_idx != 2'd0 && edge_sel == 2'd0)
      |=> (!tick || sel_idx != $past(sel_idx) || edge_sel != $past(edge_sel)));

   // R4: after stopping, the phase restarts so no tick can be pending
   p_stop_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (psc_q == '0));

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_on_cmp,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [7:0]       wbyte,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);
   localparam int HI_W = CNT_W - 8;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             bus_wr;

   assign bus_wr  = wr_hi || wr_lo;
   assign cnt_nxt = (clr_on_cmp && cnt_q == cmp_val) ? '0 : cnt_q + CNT_W'(1);
   assign match   = tick && !bus_wr && (cnt_nxt == cmp_val);
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bus_wr) begin
         if (wr_hi) cnt_q[CNT_W-1:8] <= wbyte[HI_W-1:0];
         if (wr_lo) cnt_q[7:0]       <= wbyte;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
      end
   end

   // R5: clear-on-compare returns the counter to zero on the next tick
   p_clear_on_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !bus_wr && clr_on_cmp && cnt_q == cmp_val) |=> (cnt_q == '0));

   // R2: without a tick or a write the counter is frozen
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> $stable(cnt_q));

   // R10: a low-byte write wins over counting
   p_wr_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo) |=> (cnt_q[7:0] == $past(wbyte)));

endmodule

// File: rtl/cmt_status.sv
module cmt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic rd_stat,
   input  logic wr_stat,
   input  logic wbit,
   output logic flag
);
   logic flag_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed_q <= 1'b0;
      else if (wr_stat)            armed_q <= 1'b0;
      else if (rd_stat && flag_q)  armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flag_q <= 1'b0;
      else if (set)                            flag_q <= 1'b1;
      else if (wr_stat && armed_q && !wbit)    flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R6: a match always leaves the flag set
   p_set_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag_q);

   // R7: writing one never clears the flag
   p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_stat && wbit) |=> flag_q);

   // R7: without a prior read the flag survives any write
   p_unread_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q) |=> flag_q);

endmodule

// File: rtl/cmt_pin.sv
module cmt_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ioc_wr,
   input  logic [3:0] ioc_new,
   input  logic [3:0] ioc_cur,
   input  logic       match,
   output logic       pin
);
   import cmt_pkg::*;

   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (ioc_wr) begin
         if (code_valid(ioc_new)) pin_q <= ioc_new[2];
      end else if (match) begin
         unique case (pin_act(ioc_cur))
            ACT_CLR: pin_q <= 1'b0;
            ACT_SET: pin_q <= 1'b1;
            ACT_TGL: pin_q <= ~pin_q;
            default: pin_q <= pin_q;
         endcase
      end
   end

   assign pin = pin_q;

   // R9: a toggle code flips the pin on every match
   p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !ioc_wr && pin_act(ioc_cur) == ACT_TGL) |=> (pin_q != $past(pin_q)));

   // R9: without a match or a code write the pin is retained
   p_retain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!match && !ioc_wr) |=> $stable(pin_q));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
   parameter int CNT_W   = 16,
   parameter int NUM_CH  = 4,
   parameter int CH_IDX  = 0,
   parameter int ADDR_W  = 4,
   parameter int NUM_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NUM_CH-1:0] run_vec,
   output logic              cmp_pin,
   output logic              irq
);
   import cmt_pkg::*;

   initial begin
      assert (CH_IDX >= 0 && CH_IDX < NUM_CH)
         else $error("cmt_channel: CH_IDX outside run_vec");
      assert (CNT_W == 16)
         else $error("cmt_channel: register map assumes a 16-bit counter");
      assert (ADDR_W >= 4)
         else $error("cmt_channel: ADDR_W too small for the map");
   end

   logic [7:0]       ctrl_q, mode_q, pinc_q, ien_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_val;
   logic             we, re, run, tick, match, flag;
   logic             cnt_wr_hi, cnt_wr_lo, stat_wr, stat_rd, pinc_wr;
   logic             unused_run;

   assign we         = bus_sel && bus_wr;
   assign re         = bus_sel && bus_rd;
   assign run        = run_vec[CH_IDX];
   assign unused_run = ^run_vec;

   assign cnt_wr_hi = we && (bus_addr == ADDR_W'(A_CNTH));
   assign cnt_wr_lo = we && (bus_addr == ADDR_W'(A_CNTL));
   assign stat_wr   = we && (bus_addr == ADDR_W'(A_STAT));
   assign stat_rd   = re && (bus_addr == ADDR_W'(A_STAT));
   assign pinc_wr   = we && (bus_addr == ADDR_W'(A_PINC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         pinc_q <= '0;
         ien_q  <= '0;
         cmp_q  <= '0;
      end else if (we) begin
         case (bus_addr)
            ADDR_W'(A_CTRL): ctrl_q <= bus_wdata;
            ADDR_W'(A_MODE): mode_q <= bus_wdata;
            ADDR_W'(A_PINC): pinc_q <= bus_wdata;
            ADDR_W'(A_IEN):  ien_q  <= bus_wdata;
            ADDR_W'(A_CMPH): cmp_q[CNT_W-1:8] <= bus_wdata;
            ADDR_W'(A_CMPL): cmp_q[7:0]       <= bus_wdata;
            default: ;
         endcase
      end
   end

   cmt_prescale #(.NUM_DIV(NUM_DIV)) i_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div_sel  (ctrl_q[1:0]),
      .edge_sel (ctrl_q[4:3]),
      .tick     (tick)
   );

   cmt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clr_on_cmp (ctrl_q[7:5] == CLR_ON_CMP),
      .cmp_val    (cmp_q),
      .wr_hi      (cnt_wr_hi),
      .wr_lo      (cnt_wr_lo),
      .wbyte      (bus_wdata),
      .cnt        (cnt_val),
      .match      (match)
   );

   cmt_status i_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (match),
      .rd_stat (stat_rd),
      .wr_stat (stat_wr),
      .wbit    (bus_wdata[0]),
      .flag    (flag)
   );

   cmt_pin i_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .ioc_wr  (pinc_wr),
      .ioc_new (bus_wdata[3:0]),
      .ioc_cur (pinc_q[3:0]),
      .match   (match),
      .pin     (cmp_pin)
   );

   assign irq = flag && ien_q[0];

   always_comb begin
      case (bus_addr)
         ADDR_W'(A_CTRL): bus_rdata = ctrl_q;
         ADDR_W'(A_MODE): bus_rdata = mode_q;
         ADDR_W'(A_PINC): bus_rdata = pinc_q;
         ADDR_W'(A_IEN):  bus_rdata = ien_q;
         ADDR_W'(A_STAT): bus_rdata = {7'b0, flag};
         ADDR_W'(A_CNTH): bus_rdata = cnt_val[CNT_W-1:8];
         ADDR_W'(A_CNTL): bus_rdata = cnt_val[7:0];
         ADDR_W'(A_CMPH): bus_rdata = cmp_q[CNT_W-1:8];
         ADDR_W'(A_CMPL): bus_rdata = cmp_q[7:0];
         default:         bus_rdata = 8'h00;
      endcase
   end

   // R2: a cleared run bit freezes the counter at the port level
   p_run_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr_hi && !cnt_wr_lo) |=> $stable(cnt_val));

   // R8: the interrupt never rises without its enable bit
   p_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ien_q[0]);

endmodule

// File: tb/test_cmt_channel.sv
`timescale 1ns/1ps
module test_cmt_channel;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] run_vec = '0;
   logic       cmp_pin, irq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [7:0] rdv;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   cmt_channel i_cmt_channel (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .run_vec(run_vec), .cmp_pin(cmp_pin), .irq(irq)
   );

   // control value, run cycles, expected count (R3, R4)
   localparam int NV = 11;
   localparam int V_CTRL [NV] = '{8'h00, 8'h01, 8'h09, 8'h11, 8'h02, 8'h0A, 8'h03, 8'h13, 8'h10, 8'h05, 8'h19};
   localparam int V_RUN  [NV] = '{10,    10,    10,    10,    40,    40,    200,   200,   7,     12,    10};
   localparam int V_EXP  [NV] = '{10,    2,     3,     5,     2,     3,     3,     6,     7,     3,     5};

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 4'(a);
      #1 rdv = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic rd_cnt(output int v);
      int h;
      rd(6); h = rdv;
      rd(7); v = (h << 8) | rdv;
   endtask

   task automatic set_cnt(input int v);
      wr(6, v >> 8);
      wr(7, v & 8'hFF);
   endtask

   task automatic run_for(input logic [3:0] m, input int k);
      @(negedge clk);
      run_vec = m;
      repeat (k) @(negedge clk);
      run_vec = '0;
   endtask

   task automatic clr_flag();
      rd(4);
      wr(4, 8'hFE);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int v, t0, t1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      foreach (V_RUN[i]) begin end
      for (int a = 0; a < 10; a++) begin
         if (a != 5) begin
            rd(a);
            chk($sformatf("R1 reg %0d", a), rdv, 0);
         end
      end
      chk("R1 irq", irq, 0);
      chk("R1 pin", cmp_pin, 0);

      // R3 and R4: prescaler and edge vectors
      wr(8, 8'hFF); wr(9, 8'hFF);
      for (int i = 0; i < NV; i++) begin
         wr(0, V_CTRL[i]);
         set_cnt(0);
         run_for(4'b0001, V_RUN[i]);
         rd_cnt(v);
         chk($sformatf("R3,R4 vector %0d", i), v, V_EXP[i]);
      end

      // R2: foreign run bits do nothing, own bit counts
      wr(0, 8'h00);
      set_cnt(0);
      run_for(4'b1110, 20);
      rd_cnt(v);
      chk("R2 other channels' run bits", v, 0);
      run_for(4'b0001, 20);
      rd_cnt(v);
      chk("R2 own run bit", v, 20);

      // R5, R6: clear on compare, divide by 1
      wr(0, 8'h20); wr(8, 0); wr(9, 3);
      set_cnt(0);
      clr_flag();
      run_for(4'b0001, 2);
      rd_cnt(v); chk("R5 count before match", v, 2);
      rd(4);     chk("R6 flag before match", rdv[0], 0);
      run_for(4'b0001, 1);
      rd_cnt(v); chk("R5 count at match", v, 3);
      rd(4);     chk("R6 flag at match", rdv[0], 1);
      run_for(4'b0001, 1);
      rd_cnt(v); chk("R5 cleared after match", v, 0);

      // R5: no clear selected, passes compare and wraps
      wr(0, 8'h00);
      set_cnt(3);
      run_for(4'b0001, 1);
      rd_cnt(v); chk("R5 no clear passes compare", v, 4);
      wr(0, 8'h40);
      set_cnt(16'hFFFE);
      run_for(4'b0001, 3);
      rd_cnt(v); chk("R5 wrap with other clear code", v, 1);

      // R7, R8: flag clear handshake and interrupt gating
      wr(0, 8'h20); wr(9, 3); wr(3, 1);
      set_cnt(2);
      run_for(4'b0001, 1);
      chk("R8 irq with enable", irq, 1);
      wr(4, 8'hFF);
      chk("R7 write one keeps flag", irq, 1);
      wr(4, 8'h00);
      chk("R7 write zero without read keeps flag", irq, 1);
      wr(3, 0);
      chk("R8 irq masked", irq, 0);
      wr(3, 1);
      chk("R8 irq unmasked", irq, 1);
      rd(4);
      chk("R7 flag reads one", rdv[0], 1);
      wr(4, 8'hFE);
      chk("R7 read then write zero clears", irq, 0);

      // R9: pin actions, compare value 1, one match per step
      wr(0, 8'h20); wr(9, 1); set_cnt(0);
      wr(2, 6);  chk("R9 code 6 start level", cmp_pin, 1);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 code 6 set on match", cmp_pin, 1);
      wr(2, 3);  chk("R9 code 3 start level", cmp_pin, 0);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 toggle first", cmp_pin, 1);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 toggle second", cmp_pin, 0);
      wr(2, 2);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 code 2 set", cmp_pin, 1);
      wr(2, 0);  chk("R9 code 0 retains on write", cmp_pin, 1);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 code 0 retains on match", cmp_pin, 1);
      wr(2, 7);  chk("R9 code 7 start level", cmp_pin, 1);
      wr(7, 0); run_for(4'b0001, 1); chk("R9 code 7 first toggle", cmp_pin, 0);

      // R10: counter write beats the count tick
      wr(0, 8'h00); wr(8, 8'hFF); wr(9, 8'hFF);
      set_cnt(0);
      @(negedge clk);
      run_vec = 4'b0001;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h50;
      @(negedge clk);
      run_vec = '0;
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd_cnt(v); chk("R10 write overrides count", v, 16'h0050);

      // R11: mode register stored, counting unchanged
      wr(1, 8'h0F);
      rd(1); chk("R11 mode readback", rdv, 8'h0F);
      set_cnt(0);
      run_for(4'b0001, 5);
      rd_cnt(v); chk("R11 counting in other mode value", v, 5);

      // R12: periodic interrupt, divide by 64, compare 2
      wr(0, 8'h23); wr(8, 0); wr(9, 2); wr(3, 1);
      set_cnt(0);
      clr_flag();
      @(negedge clk);
      run_vec = 4'b0001;
      while (!irq) @(negedge clk);
      t0 = cyc;
      clr_flag();
      chk("R7 irq low after acknowledge", irq, 0);
      while (!irq) @(negedge clk);
      t1 = cyc;
      run_vec = '0;
      chk("R12 period in cycles", t1 - t0, 192);

      summary();
      $finish;
   end

endmodule